// File: doc/BRIEF.md
# Page access-rights and protection-key checker

This block rules on one memory access to a linear address whose translation has already been looked up. Each request gives the access kind, the privilege of the access, the user or supervisor ownership of the address, the paging mode, the no-execute enable and write-protect controls, the protection-key enable, the execute-disable bit of each paging level, and the protection key taken from the leaf entry. One clock later the block answers allow, or fault with a reason code and the page-fault vector.

A 32-bit key-rights register lives inside the block and has its own write port. For each of the 16 keys it holds one bit that blocks all data access and one bit that blocks writes. Keys act only on data accesses to user-mode addresses, and only while key checking is enabled under 64-bit paging. The execute-disable check acts only on instruction fetches. The ordinary read/write and user/supervisor bit checks of a page entry are left to other logic.

Top module: `access_guard`

## Requirements
- R1: While reset is high and on the first cycle after it, resp_valid, resp_allow and resp_fault are 0, resp_reason is 00 and resp_vector is 0. Reset clears the rights register to all zeros, so every key grants full access.
- R2: A request accepted with req_valid=1 gets its answer on the next cycle with resp_valid=1. In a cycle after req_valid=0, resp_valid is 0 and resp_reason is 00.
- R3: A request uses the rights register value held before the clock edge that accepts it. A rights write made in the same cycle as a request takes effect for the next request.
- R4: When req_mapped=0 (no translation), resp_reason is 01 whatever the other inputs are. This reason outranks all others.
- R5: An instruction fetch (req_kind=0) from a supervisor-mode address (req_user_addr=0) gets resp_reason 10.
- R6: A fetch from a user-mode address is allowed when pg_mode=0 (32-bit paging) or nx_en=0, whatever the execute-disable bits are.
- R7: With pg_mode 1 (PAE) or 2 (64-bit), and nx_en=1, a fetch from a user-mode address gets resp_reason 10 if any level whose bit in lvl_valid is 1 also has its bit in xd_bits set. Levels with lvl_valid=0 are ignored.
- R8: Key k's access-disable bit is rights bit 2k. When key checking applies and this bit is 1, every data access (req_kind 1=read, 2=write) to that user-mode address gets resp_reason 11, at either privilege.
- R9: Key k's write-disable bit is rights bit 2k+1. When it is 1, a user-privilege write gets reason 11. A supervisor-privilege write (req_sup=1) gets reason 11 only when wp=1. Reads are not affected by this bit.
- R10: Keys are ignored unless pk_en=1 and pg_mode=2.
- R11: Keys never deny an instruction fetch, and never deny an access to a supervisor-mode address.
- R12: With resp_valid=1, resp_allow=1 exactly when resp_reason is 00. Otherwise resp_fault=1 and resp_vector is 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rights_we | input | 1 | Write enable for the key-rights register |
| rights_wdata | input | 32 | New key-rights value |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write (3 handled as read) |
| req_sup | input | 1 | 1 = supervisor-privilege access |
| req_user_addr | input | 1 | 1 = user-mode address, 0 = supervisor-mode address |
| req_mapped | input | 1 | 1 = a translation exists |
| pg_mode | input | 2 | 0 32-bit, 1 PAE, 2 64-bit (3 handled as PAE) |
| nx_en | input | 1 | No-execute enable |
| wp | input | 1 | Write-protect control |
| pk_en | input | 1 | Protection-key enable |
| xd_bits | input | 4 | Execute-disable bit of each paging level |
| lvl_valid | input | 4 | Marks which levels take part in the translation |
| leaf_key | input | 4 | Protection key from the leaf entry |
| resp_valid | output | 1 | Answer present |
| resp_allow | output | 1 | Access permitted |
| resp_fault | output | 1 | Page fault raised |
| resp_reason | output | 2 | 00 ok, 01 no translation, 10 execute denied, 11 key denied |
| resp_vector | output | 8 | 14 on a fault, else 0 |

## Verification
Two things can land in the same cycle: a rights-register write and a key-checked request. The bench drives both on one edge, with the new value flipping the access-disable bit of the key in use. It expects the answer to follow the old value, and the next request to follow the new value. A second collision is a missing translation on a request that would also fail the execute or key check. The bench judges this by requiring the no-translation reason every time.

// File: rtl/acg_pkg.sv
package acg_pkg;

    localparam int NUM_KEYS = 16;
    localparam int KEY_W    = $clog2(NUM_KEYS);
    localparam int RIGHTS_W = 2 * NUM_KEYS;
    localparam int LEVELS   = 4;
    localparam logic [7:0] PF_VECTOR = 8'd14;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PG_LEGACY = 2'd0,
        PG_PAE    = 2'd1,
        PG_LONG   = 2'd2,
        PG_RSVD   = 2'd3
    } pg_mode_e;

    typedef enum logic [1:0] {
        RSN_OK     = 2'd0,
        RSN_NOXLAT = 2'd1,
        RSN_EXEC   = 2'd2,
        RSN_KEY    = 2'd3
    } reason_e;

    typedef struct packed {
        logic    valid;
        reason_e reason;
    } verdict_t;

    function automatic reason_e rank_reason(input logic mapped,
                                            input logic exec_deny,
                                            input logic key_deny);
        if (!mapped)        return RSN_NOXLAT;
        else if (exec_deny) return RSN_EXEC;
        else if (key_deny)  return RSN_KEY;
        else                return RSN_OK;
    endfunction

    function automatic logic is_data(input acc_kind_e k);
        return k != ACC_FETCH;
    endfunction

endpackage

// File: rtl/acg_rights_reg.sv
module acg_rights_reg #(
    parameter int WIDTH = acg_pkg::RIGHTS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/acg_exec_gate.sv
module acg_exec_gate
    import acg_pkg::*;
#(
    parameter int NLVL = LEVELS
) (
    input  acc_kind_e       kind,
    input  logic            user_addr,
    input  pg_mode_e        mode,
    input  logic            nx_en,
    input  logic [NLVL-1:0] xd,
    input  logic [NLVL-1:0] lvl,
    output logic            deny
);
    logic xd_any;
    logic nx_live;

    always_comb begin
        xd_any  = |(xd & lvl);
        nx_live = nx_en && (mode != PG_LEGACY);
        deny    = 1'b0;
        if (kind == ACC_FETCH)
            deny = !user_addr || (nx_live && xd_any);
    end
endmodule

// File: rtl/acg_key_gate.sv
module acg_key_gate
    import acg_pkg::*;
#(
    parameter int NK = NUM_KEYS,
    localparam int KW = $clog2(NK),
    localparam int RW = 2 * NK
) (
    input  logic [RW-1:0] rights,
    input  logic [KW-1:0] key,
    input  acc_kind_e     kind,
    input  logic          sup,
    input  logic          user_addr,
    input  pg_mode_e      mode,
    input  logic          pk_en,
    input  logic          wp,
    output logic          deny
);
    logic [NK-1:0] ad_vec;
    logic [NK-1:0] wd_vec;

    for (genvar k = 0; k < NK; k++) begin : g_split
        assign ad_vec[k] = rights[2*k];
        assign wd_vec[k] = rights[2*k+1];
    end

    logic active;
    logic ad_hit;
    logic wd_hit;

    always_comb begin
        active = pk_en && (mode == PG_LONG) && user_addr && is_data(kind);
        ad_hit = ad_vec[key];
        wd_hit = wd_vec[key] && (kind == ACC_WRITE) && (!sup || wp);
        deny   = active && (ad_hit || wd_hit);
    end
endmodule

// File: rtl/access_guard.sv
module access_guard
    import acg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rights_we,
    input  logic [31:0] rights_wdata,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_sup,
    input  logic        req_user_addr,
    input  logic        req_mapped,
    input  logic [1:0]  pg_mode,
    input  logic        nx_en,
    input  logic        wp,
    input  logic        pk_en,
    input  logic [3:0]  xd_bits,
    input  logic [3:0]  lvl_valid,
    input  logic [3:0]  leaf_key,
    output logic        resp_valid,
    output logic        resp_allow,
    output logic        resp_fault,
    output logic [1:0]  resp_reason,
    output logic [7:0]  resp_vector
);
    acc_kind_e kind;
    pg_mode_e  mode;
    assign kind = acc_kind_e'(req_kind);
    assign mode = pg_mode_e'(pg_mode);

    logic [RIGHTS_W-1:0] rights_q;

    acg_rights_reg #(.WIDTH(RIGHTS_W)) u_rights (
        .clk   (clk),
        .rst   (rst),
        .we    (rights_we),
        .wdata (rights_wdata),
        .q     (rights_q)
    );

    logic exec_deny;
    logic key_deny;

    acg_exec_gate #(.NLVL(LEVELS)) u_exec (
        .kind      (kind),
        .user_addr (req_user_addr),
        .mode      (mode),
        .nx_en     (nx_en),
        .xd        (xd_bits),
        .lvl       (lvl_valid),
        .deny      (exec_deny)
    );

    acg_key_gate #(.NK(NUM_KEYS)) u_key (
        .rights    (rights_q),
        .key       (leaf_key),
        .kind      (kind),
        .sup       (req_sup),
        .user_addr (req_user_addr),
        .mode      (mode),
        .pk_en     (pk_en),
        .wp        (wp),
        .deny      (key_deny)
    );

    verdict_t next_v;
    verdict_t cur_v;

    always_comb begin
        next_v.valid  = req_valid;
        next_v.reason = req_valid ? rank_reason(req_mapped, exec_deny, key_deny)
                                  : RSN_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_v.valid  <= 1'b0;
            cur_v.reason <= RSN_OK;
        end else begin
            cur_v <= next_v;
        end
    end

    assign resp_valid  = cur_v.valid;
    assign resp_reason = cur_v.reason;
    assign resp_allow  = cur_v.valid && (cur_v.reason == RSN_OK);
    assign resp_fault  = cur_v.valid && (cur_v.reason != RSN_OK);
    assign resp_vector = resp_fault ? PF_VECTOR : 8'd0;
endmodule

// File: rtl/acg_checker.sv
module acg_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       req_user_addr,
    input logic       req_mapped,
    input logic       pk_en,
    input logic       resp_valid,
    input logic       resp_allow,
    input logic       resp_fault,
    input logic [1:0] resp_reason,
    input logic [7:0] resp_vector
);
    p_answer_next_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    p_quiet_next_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!resp_valid && resp_reason == 2'b00));

    p_noxlat_first_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_mapped) |=> (resp_reason == 2'b01));

    p_sup_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mapped && req_kind == 2'd0 && !req_user_addr)
        |=> (resp_reason == 2'b10));

    p_fetch_nokey_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0) |=> (resp_reason != 2'b11));

    p_supaddr_data_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mapped && req_kind != 2'd0 && !req_user_addr)
        |=> resp_allow);

    p_keys_off_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mapped && req_kind != 2'd0 && !pk_en) |=> resp_allow);

    p_fault_vec_r12: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> (resp_vector == 8'd14 && !resp_allow));

    p_one_verdict_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_allow, resp_fault}));
endmodule

bind access_guard acg_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_user_addr (req_user_addr),
    .req_mapped    (req_mapped),
    .pk_en         (pk_en),
    .resp_valid    (resp_valid),
    .resp_allow    (resp_allow),
    .resp_fault    (resp_fault),
    .resp_reason   (resp_reason),
    .resp_vector   (resp_vector)
);

// File: tb/sim_access_guard.sv
`timescale 1ns/1ps
module sim_access_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rights_we = 1'b0;
    logic [31:0] rights_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_sup = 1'b0;
    logic        req_user_addr = 1'b0;
    logic        req_mapped = 1'b0;
    logic [1:0]  pg_mode = '0;
    logic        nx_en = 1'b0;
    logic        wp = 1'b0;
    logic        pk_en = 1'b0;
    logic [3:0]  xd_bits = '0;
    logic [3:0]  lvl_valid = '0;
    logic [3:0]  leaf_key = '0;
    logic        resp_valid, resp_allow, resp_fault;
    logic [1:0]  resp_reason;
    logic [7:0]  resp_vector;

    int total = 0;
    int bad = 0;
    logic [31:0] shadow = '0;

    always #2.5 clk = ~clk;

    access_guard u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [1:0] k, input logic s, input logic u,
                                         input logic m, input logic [1:0] md, input logic nx,
                                         input logic w, input logic pk, input logic [3:0] xd,
                                         input logic [3:0] lv, input logic [3:0] key,
                                         input logic [31:0] rt);
        logic ad, wd;
        if (!m) return 2'b01;
        if (k == 2'd0) begin
            if (!u) return 2'b10;
            if (md != 2'd0 && nx && ((xd & lv) != 4'd0)) return 2'b10;
            return 2'b00;
        end
        if (!(pk && md == 2'd2 && u)) return 2'b00;
        ad = rt[2*key];
        wd = rt[2*key+1];
        if (ad) return 2'b11;
        if (wd && k == 2'd2 && (!s || w)) return 2'b11;
        return 2'b00;
    endfunction

    // Drive one request at a negedge, sample its answer at the following negedge.
    task automatic send(input string req, input logic [1:0] k, input logic s, input logic u,
                        input logic m, input logic [1:0] md, input logic nx, input logic w,
                        input logic pk, input logic [3:0] xd, input logic [3:0] lv,
                        input logic [3:0] key);
        logic [1:0] e;
        e = model(k, s, u, m, md, nx, w, pk, xd, lv, key, shadow);
        req_valid = 1; req_kind = k; req_sup = s; req_user_addr = u; req_mapped = m;
        pg_mode = md; nx_en = nx; wp = w; pk_en = pk; xd_bits = xd; lvl_valid = lv;
        leaf_key = key;
        @(negedge clk);
        req_valid = 0;
        check({req, " valid"}, {31'd0, resp_valid}, 32'd1);
        check({req, " reason"}, {30'd0, resp_reason}, {30'd0, e});
        check({req, " allow"}, {31'd0, resp_allow}, {31'd0, e == 2'b00});
        check({req, " R12 vector"}, {24'd0, resp_vector}, (e != 2'b00) ? 32'd14 : 32'd0);
    endtask

    task automatic write_rights(input logic [31:0] v);
        rights_we = 1; rights_wdata = v;
        @(negedge clk);
        rights_we = 0;
        shadow = v;
    endtask

    task automatic t_reset;
        check("R1 valid", {31'd0, resp_valid}, 32'd0);
        check("R1 fault", {31'd0, resp_fault}, 32'd0);
        check("R1 reason", {30'd0, resp_reason}, 32'd0);
        // rights cleared: key checks on a fully enabled path still allow
        send("R1 rights clear", 2'd2, 0, 1, 1, 2'd2, 1, 1, 1, 4'h0, 4'hF, 4'd9);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 idle valid", {31'd0, resp_valid}, 32'd0);
        check("R2 idle reason", {30'd0, resp_reason}, 32'd0);
    endtask

    task automatic t_noxlat;
        write_rights(32'hFFFF_FFFF);
        send("R4 fetch sup", 2'd0, 0, 0, 0, 2'd2, 1, 1, 1, 4'hF, 4'hF, 4'd3);
        send("R4 data key", 2'd2, 0, 1, 0, 2'd2, 1, 1, 1, 4'h0, 4'hF, 4'd3);
        write_rights(32'h0);
    endtask

    task automatic t_fetch;
        send("R5 sup addr", 2'd0, 1, 0, 1, 2'd0, 0, 0, 0, 4'h0, 4'hF, 4'd0);
        send("R6 legacy xd", 2'd0, 0, 1, 1, 2'd0, 1, 0, 0, 4'hF, 4'hF, 4'd0);
        send("R6 nx off", 2'd0, 0, 1, 1, 2'd2, 0, 0, 0, 4'hF, 4'hF, 4'd0);
        send("R7 pae xd", 2'd0, 0, 1, 1, 2'd1, 1, 0, 0, 4'h4, 4'h7, 4'd0);
        send("R7 long xd", 2'd0, 1, 1, 1, 2'd2, 1, 0, 0, 4'h1, 4'hF, 4'd0);
        send("R7 invalid lvl", 2'd0, 0, 1, 1, 2'd2, 1, 0, 0, 4'h8, 4'h7, 4'd0);
        send("R7 clear", 2'd0, 0, 1, 1, 2'd2, 1, 0, 0, 4'h0, 4'hF, 4'd0);
    endtask

    task automatic t_ad;
        write_rights(32'h0000_0001 << (2*5));
        send("R8 user read", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd5);
        send("R8 sup write", 2'd2, 1, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd5);
        send("R8 other key", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd4);
        write_rights(32'h0000_0001 << 30);
        send("R8 key15", 2'd1, 1, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd15);
    endtask

    task automatic t_wd;
        write_rights(32'h0000_0002 << (2*7));
        send("R9 user write", 2'd2, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd7);
        send("R9 user read", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd7);
        send("R9 sup write wp0", 2'd2, 1, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd7);
        send("R9 sup write wp1", 2'd2, 1, 1, 1, 2'd2, 0, 1, 1, 4'h0, 4'hF, 4'd7);
    endtask

    task automatic t_keys_off;
        write_rights(32'hFFFF_FFFF);
        send("R10 pk off", 2'd2, 0, 1, 1, 2'd2, 0, 1, 0, 4'h0, 4'hF, 4'd2);
        send("R10 pae", 2'd1, 0, 1, 1, 2'd1, 0, 1, 1, 4'h0, 4'hF, 4'd2);
        send("R10 legacy", 2'd2, 0, 1, 1, 2'd0, 0, 1, 1, 4'h0, 4'hF, 4'd2);
        send("R11 fetch", 2'd0, 0, 1, 1, 2'd2, 1, 1, 1, 4'h0, 4'hF, 4'd2);
        send("R11 sup addr", 2'd2, 0, 0, 1, 2'd2, 0, 1, 1, 4'h0, 4'hF, 4'd2);
        write_rights(32'h0);
    endtask

    task automatic t_same_cycle;
        // rights write and request on the same edge: old value governs
        rights_we = 1; rights_wdata = 32'h0000_0001 << (2*3);
        send("R3 old value", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd3);
        rights_we = 0;
        shadow = 32'h0000_0001 << (2*3);
        send("R3 new value", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd3);
        rights_we = 1; rights_wdata = 32'h0;
        send("R3 old again", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd3);
        rights_we = 0;
        shadow = 32'h0;
        send("R3 cleared", 2'd1, 0, 1, 1, 2'd2, 0, 0, 1, 4'h0, 4'hF, 4'd3);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {31'd0, resp_valid}, 32'd0);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_noxlat();
        t_fetch();
        t_ad();
        t_wd();
        t_keys_off();
        t_same_cycle();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule